// File: doc/BRIEF.md
# Priority-Gated Page Cache with Victim Buffer

This block is a page-granular cache controller that sits between a processor's page requests and a sequencer that reads whole pages out of flash. It keeps only tag, valid and priority state, because the page data itself lives elsewhere. The main store is direct-mapped, with the low bits of the page number picking the line. Next to it sits a small fully associative victim buffer that holds lines recently pushed out of the main store. Every request probes both structures in the same cycle. A hit in either one answers one cycle after the request is taken. A hit in the victim buffer also swaps that line with the main-store line that shares its index.

When a request misses both structures, the controller issues one fill request to the flash reader and stalls the requester until the reader reports completion. The reader also supplies the page's priority class, which it takes from the page's spare area. If the target line is empty, the page is installed whatever its class. If the line is occupied, a page of any class other than low takes the line and pushes the old occupant into the victim buffer. A low-priority page never displaces a resident line. Instead the controller pulses a redirect to the address translation block, which then serves that page from a copy in system memory.

The victim buffer is sized near one sixty-fourth of the main store. It replaces its least recently used entry, and the entry it displaces is discarded.

Top module: `prio_page_cache`

## Requirements
- R1: After reset every line and victim entry is invalid, `req_ready` is 1, and `rsp_valid`, `fill_req` and `redir_valid` are 0. A reset in mid-operation discards all cached pages.
- R2: A request whose page is resident in the main store gives `rsp_valid` with `rsp_kind` = 2'b00 on the cycle after acceptance. `rsp_prio` is the stored class, and no fill request is issued.
- R3: A request that misses both structures raises `fill_req` for exactly one cycle on the cycle after acceptance, with `fill_page` equal to the requested page. `req_ready` stays 0 and `fill_page` stays stable until `fill_done` is seen.
- R4: When `fill_done` arrives and the indexed main line is empty, the page is installed whatever its class. The response, one cycle later, has `rsp_kind` = 2'b10 and `rsp_prio` equal to `fill_prio`.
- R5: When a page of a class other than low fills an occupied line, the new page takes the line and the old occupant moves to the victim buffer. The response has `rsp_kind` = 2'b10, and a main line and a victim entry never hold the same page.
- R6: When a low-class page (`fill_prio` = 2'b00) fills an occupied line, the resident line stays and the page is not cached. On the same cycle as the response, `redir_valid` pulses with `redir_page` equal to the page, and the response has `rsp_kind` = 2'b11 and `rsp_prio` = 2'b00.
- R7: A victim-buffer hit answers on the next cycle with `rsp_kind` = 2'b01 and the entry's stored class. The hit line returns to the main store and the former main occupant takes its victim entry.
- R8: When the victim buffer is full, a new eviction overwrites the least recently used entry, where a victim hit or an insertion counts as a use. The dropped page then misses both structures.
- R9: `fill_done` has no effect while no fill is outstanding, `req_valid` is ignored while a fill is outstanding, and `rsp_valid` is only ever high while `req_ready` is high.
- R10: Class codes are 2'b00 low, 2'b01 mid and 2'b10 high. The code 2'b11 is handled as a non-low class and is reported back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Page request strobe, taken when `req_ready` is 1 |
| req_page | input | PAGE_W | Requested page number |
| req_ready | output | 1 | Controller can take a request (no fill outstanding) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | 00 main hit, 01 victim hit, 10 filled, 11 redirected |
| rsp_prio | output | 2 | Priority class of the page served |
| fill_req | output | 1 | One-cycle request to the flash page reader |
| fill_page | output | PAGE_W | Page to be read |
| fill_done | input | 1 | Reader finished the outstanding page |
| fill_prio | input | 2 | Priority class read from the page's spare area |
| redir_valid | output | 1 | One-cycle notice that the page is served from system memory |
| redir_page | output | PAGE_W | Page being redirected |

## Verification
The cycle-level rules are checked on every cycle. These are the single-cycle fill strobe, the stall and the held fill address while a fill is outstanding, and the next-cycle response to a main or victim hit. They also cover the pairing of a redirect with its response, and the rule that the two structures never both claim a page. Only the bench's request sequences can show the effects that depend on stored state. These are whether a low-class page really left the resident line in place, whether a swap really exchanged the two lines, which victim entry least-recently-used replacement discarded, and that stray `fill_done` pulses and requests made during a stall leave no trace.

// File: rtl/pc_pkg.sv
package pc_pkg;

  typedef enum logic [1:0] {
    RSP_MAIN  = 2'b00,
    RSP_VICT  = 2'b01,
    RSP_FILL  = 2'b10,
    RSP_REDIR = 2'b11
  } rsp_kind_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } ctl_state_t;

  localparam logic [1:0] PRIO_LOW = 2'b00;

  // a page may be gated out of an occupied line only for the low class
  function automatic logic prio_is_low(input logic [1:0] p);
    return p == PRIO_LOW;
  endfunction

endpackage

// File: rtl/pc_main_tags.sv
module pc_main_tags #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [1:0]       rd_prio,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [1:0]       wr_prio
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] line_vld;
  logic [TAG_W-1:0] line_tag  [LINES];
  logic [1:0]       line_prio [LINES];

  assign rd_valid = line_vld[rd_idx];
  assign rd_tag   = line_tag[rd_idx];
  assign rd_prio  = line_prio[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_vld <= '0;
    end else if (wr_en) begin
      line_vld[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_tag[wr_idx]  <= wr_tag;
      line_prio[wr_idx] <= wr_prio;
    end
  end

endmodule

// File: rtl/pc_victim_buf.sv
module pc_victim_buf #(
  parameter int PAGE_W = 12,
  parameter int N      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PAGE_W-1:0]    lk_page,
  output logic                 hit,
  output logic [N-1:0]         hit_vec,
  output logic [$clog2(N)-1:0] hit_idx,
  output logic [1:0]           hit_prio,
  input  logic                 swap_en,
  input  logic [$clog2(N)-1:0] swap_idx,
  input  logic                 swap_keep,
  input  logic [PAGE_W-1:0]    swap_page,
  input  logic [1:0]           swap_prio,
  input  logic                 ins_en,
  input  logic [PAGE_W-1:0]    ins_page,
  input  logic [1:0]           ins_prio
);
  localparam int SW = $clog2(N);

  logic [N-1:0]      ent_vld;
  logic [PAGE_W-1:0] ent_page [N];
  logic [1:0]        ent_prio [N];
  // ages form a permutation of 0..N-1; N-1 marks the least recently used
  logic [SW-1:0]     ent_age  [N];

  logic [SW-1:0] ins_slot;
  logic          any_free;
  logic          touch_en;
  logic [SW-1:0] touch_idx;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_vld[g] && (ent_page[g] == lk_page);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx  = '0;
    hit_prio = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_idx  = SW'(i);
        hit_prio = ent_prio[i];
      end
    end
  end

  // free entry with the lowest index first, otherwise the oldest entry
  always_comb begin
    any_free = 1'b0;
    ins_slot = '0;
    for (int i = 0; i < N; i++) begin
      if (ent_age[i] == SW'(N - 1)) ins_slot = SW'(i);
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_vld[i]) begin
        any_free = 1'b1;
        ins_slot = SW'(i);
      end
    end
  end

  assign touch_en  = swap_en || ins_en;
  assign touch_idx = swap_en ? swap_idx : ins_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      for (int i = 0; i < N; i++) ent_age[i] <= SW'(i);
    end else begin
      if (swap_en) begin
        ent_vld[swap_idx] <= swap_keep;
      end else if (ins_en) begin
        ent_vld[ins_slot] <= 1'b1;
      end
      if (touch_en) begin
        for (int i = 0; i < N; i++) begin
          if (SW'(i) == touch_idx) begin
            ent_age[i] <= '0;
          end else if (ent_age[i] < ent_age[touch_idx]) begin
            ent_age[i] <= ent_age[i] + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (swap_en) begin
      ent_page[swap_idx] <= swap_page;
      ent_prio[swap_idx] <= swap_prio;
    end else if (ins_en) begin
      ent_page[ins_slot] <= ins_page;
      ent_prio[ins_slot] <= ins_prio;
    end
  end

  logic unused_free;
  assign unused_free = any_free;

endmodule

// File: rtl/prio_page_cache.sv
module prio_page_cache
  import pc_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 8,
  parameter int VICT_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PAGE_W-1:0] req_page,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [1:0]        rsp_prio,
  output logic              fill_req,
  output logic [PAGE_W-1:0] fill_page,
  input  logic              fill_done,
  input  logic [1:0]        fill_prio,
  output logic              redir_valid,
  output logic [PAGE_W-1:0] redir_page
);
  localparam int TAG_W = PAGE_W - IDX_W;
  localparam int VSW   = $clog2(VICT_N);

  function automatic logic [IDX_W-1:0] page_idx(input logic [PAGE_W-1:0] p);
    return p[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] page_tag(input logic [PAGE_W-1:0] p);
    return p[PAGE_W-1:IDX_W];
  endfunction

  function automatic logic [PAGE_W-1:0] page_join(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  ctl_state_t        state;
  logic [PAGE_W-1:0] cur_page;
  logic [PAGE_W-1:0] lk_page;

  logic              m_valid;
  logic [TAG_W-1:0]  m_tag;
  logic [1:0]        m_prio;
  logic              main_hit;
  logic [PAGE_W-1:0] m_page;

  logic              v_hit;
  logic [VICT_N-1:0] v_hit_vec;
  logic [VSW-1:0]    v_hit_idx;
  logic [1:0]        v_prio;

  // named internal events, also observed by the bound checker
  logic accept, fill_end;
  logic evt_main_hit, evt_vict_swap, evt_fill_start;
  logic evt_redirect, evt_install, evt_evict;

  logic              mt_we;
  logic [1:0]        mt_wprio;

  assign lk_page  = (state == ST_FILL) ? cur_page : req_page;
  assign m_page   = page_join(m_tag, page_idx(lk_page));
  assign main_hit = m_valid && (m_tag == page_tag(lk_page));

  assign accept         = (state == ST_IDLE) && req_valid;
  assign evt_main_hit   = accept && main_hit;
  assign evt_vict_swap  = accept && !main_hit && v_hit;
  assign evt_fill_start = accept && !main_hit && !v_hit;
  assign fill_end       = (state == ST_FILL) && fill_done;
  assign evt_redirect   = fill_end && m_valid && prio_is_low(fill_prio);
  assign evt_install    = fill_end && !evt_redirect;
  assign evt_evict      = evt_install && m_valid;

  assign mt_we    = evt_vict_swap || evt_install;
  assign mt_wprio = evt_vict_swap ? v_prio : fill_prio;

  pc_main_tags #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (page_idx(lk_page)),
    .rd_valid (m_valid),
    .rd_tag   (m_tag),
    .rd_prio  (m_prio),
    .wr_en    (mt_we),
    .wr_idx   (page_idx(lk_page)),
    .wr_tag   (page_tag(lk_page)),
    .wr_prio  (mt_wprio)
  );

  pc_victim_buf #(
    .PAGE_W (PAGE_W),
    .N      (VICT_N)
  ) u_vict (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_page   (lk_page),
    .hit       (v_hit),
    .hit_vec   (v_hit_vec),
    .hit_idx   (v_hit_idx),
    .hit_prio  (v_prio),
    .swap_en   (evt_vict_swap),
    .swap_idx  (v_hit_idx),
    .swap_keep (m_valid),
    .swap_page (m_page),
    .swap_prio (m_prio),
    .ins_en    (evt_evict),
    .ins_page  (m_page),
    .ins_prio  (m_prio)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_page    <= '0;
      rsp_valid   <= 1'b0;
      rsp_kind    <= RSP_MAIN;
      rsp_prio    <= '0;
      fill_req    <= 1'b0;
      fill_page   <= '0;
      redir_valid <= 1'b0;
      redir_page  <= '0;
    end else begin
      rsp_valid   <= 1'b0;
      fill_req    <= 1'b0;
      redir_valid <= 1'b0;
      if (evt_main_hit) begin
        rsp_valid <= 1'b1;
        rsp_kind  <= RSP_MAIN;
        rsp_prio  <= m_prio;
      end else if (evt_vict_swap) begin
        rsp_valid <= 1'b1;
        rsp_kind  <= RSP_VICT;
        rsp_prio  <= v_prio;
      end else if (evt_fill_start) begin
        state     <= ST_FILL;
        cur_page  <= req_page;
        fill_req  <= 1'b1;
        fill_page <= req_page;
      end else if (fill_end) begin
        state     <= ST_IDLE;
        rsp_valid <= 1'b1;
        rsp_prio  <= fill_prio;
        rsp_kind  <= evt_redirect ? RSP_REDIR : RSP_FILL;
        if (evt_redirect) begin
          redir_valid <= 1'b1;
          redir_page  <= cur_page;
        end
      end
    end
  end

endmodule

// File: rtl/pc_cache_chk.sv
module pc_cache_chk
  import pc_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int VICT_N = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic              fill_req,
  input logic              fill_done,
  input logic [PAGE_W-1:0] fill_page,
  input logic              redir_valid,
  input logic              evt_main_hit,
  input logic              evt_vict_swap,
  input logic              main_hit,
  input logic              v_hit,
  input logic [VICT_N-1:0] v_hit_vec
);

  // R3
  fill_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> !fill_req);

  // R3
  fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);

  // R3
  fill_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !fill_done) |=> $stable(fill_page));

  // R2
  main_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_main_hit |=> (rsp_valid && rsp_kind == RSP_MAIN));

  // R7
  vict_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vict_swap |=> (rsp_valid && rsp_kind == RSP_VICT));

  // R5
  excl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(v_hit_vec) && !(main_hit && v_hit));

  // R6
  redir_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (rsp_valid && rsp_kind == RSP_REDIR));

  // R9
  rsp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

endmodule

bind prio_page_cache pc_cache_chk #(
  .PAGE_W (PAGE_W),
  .VICT_N (VICT_N)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_kind      (rsp_kind),
  .fill_req      (fill_req),
  .fill_done     (fill_done),
  .fill_page     (fill_page),
  .redir_valid   (redir_valid),
  .evt_main_hit  (evt_main_hit),
  .evt_vict_swap (evt_vict_swap),
  .main_hit      (main_hit),
  .v_hit         (v_hit),
  .v_hit_vec     (v_hit_vec)
);

// File: tb/prio_page_cache_tb.sv
module prio_page_cache_tb;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [PW-1:0] req_page = '0;
  logic          req_ready;
  logic          rsp_valid;
  logic [1:0]    rsp_kind;
  logic [1:0]    rsp_prio;
  logic          fill_req;
  logic [PW-1:0] fill_page;
  logic          fill_done = 1'b0;
  logic [1:0]    fill_prio = '0;
  logic          redir_valid;
  logic [PW-1:0] redir_page;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  prio_page_cache #(.PAGE_W(PW), .IDX_W(8), .VICT_N(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_prio(rsp_prio), .fill_req(fill_req), .fill_page(fill_page),
    .fill_done(fill_done), .fill_prio(fill_prio), .redir_valid(redir_valid),
    .redir_page(redir_page)
  );

  // kinds: 0 main hit, 1 victim hit, 2 filled, 3 redirected
  // fields: page, class given by reader, expected kind, expected class
  localparam logic [17:0] VEC [23] = '{
    {12'h005, 2'd2, 2'd2, 2'd2},
    {12'h005, 2'd0, 2'd0, 2'd2},
    {12'h105, 2'd0, 2'd3, 2'd0},
    {12'h005, 2'd0, 2'd0, 2'd2},
    {12'h105, 2'd0, 2'd3, 2'd0},
    {12'h105, 2'd1, 2'd2, 2'd1},
    {12'h005, 2'd0, 2'd1, 2'd2},
    {12'h105, 2'd0, 2'd1, 2'd1},
    {12'h105, 2'd0, 2'd0, 2'd1},
    {12'h0A0, 2'd0, 2'd2, 2'd0},
    {12'h0A0, 2'd0, 2'd0, 2'd0},
    {12'h1A0, 2'd3, 2'd2, 2'd3},
    {12'h0A0, 2'd0, 2'd1, 2'd0},
    {12'h010, 2'd2, 2'd2, 2'd2},
    {12'h110, 2'd2, 2'd2, 2'd2},
    {12'h210, 2'd2, 2'd2, 2'd2},
    {12'h005, 2'd0, 2'd1, 2'd2},
    {12'h310, 2'd1, 2'd2, 2'd1},
    {12'h1A0, 2'd2, 2'd2, 2'd2},
    {12'h105, 2'd0, 2'd1, 2'd1},
    {12'h010, 2'd0, 2'd3, 2'd0},
    {12'h110, 2'd0, 2'd1, 2'd2},
    {12'h310, 2'd0, 2'd1, 2'd1}
  };

  function automatic string vec_tag(input int i, input logic [1:0] k);
    if (i >= 17 && i <= 20) return "R8";
    if (i == 11) return "R10";
    if (i == 5) return "R5";
    if (i == 9) return "R4";
    case (k)
      2'd0: return "R2";
      2'd1: return "R7";
      2'd2: return "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  logic [1:0]    a_kind, a_prio;
  logic          a_rsp, a_redir, a_stall;
  logic [PW-1:0] a_rpage, a_fpage;
  int            a_fills;

  // one request; a fill is answered after one stalled cycle
  task automatic access(input logic [PW-1:0] pg, input logic [1:0] fp);
    a_fills = 0; a_stall = 1'b1; a_fpage = '0;
    @(negedge clk); req_valid = 1'b1; req_page = pg;
    @(negedge clk); req_valid = 1'b0;
    if (!rsp_valid) begin
      if (fill_req) begin a_fills++; a_fpage = fill_page; end
      if (req_ready) a_stall = 1'b0;
      @(negedge clk);
      if (fill_req) a_fills++;
      if (req_ready) a_stall = 1'b0;
      fill_done = 1'b1; fill_prio = fp;
      @(negedge clk); fill_done = 1'b0;
    end
    a_rsp = rsp_valid; a_kind = rsp_kind; a_prio = rsp_prio;
    a_redir = redir_valid; a_rpage = redir_page;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", "req_ready", 32'(req_ready), 32'd1);
    check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1", "fill_req", 32'(fill_req), 32'd0);
    check("R1", "redir_valid", 32'(redir_valid), 32'd0);

    for (int i = 0; i < 23; i++) begin
      logic [PW-1:0] pg;
      logic [1:0] fp, ek, ep;
      string t;
      {pg, fp, ek, ep} = VEC[i];
      t = vec_tag(i, ek);
      access(pg, fp);
      check(t, $sformatf("v%0d rsp_valid", i), 32'(a_rsp), 32'd1);
      check(t, $sformatf("v%0d kind", i), 32'(a_kind), 32'(ek));
      check(t, $sformatf("v%0d class", i), 32'(a_prio), 32'(ep));
      check(t, $sformatf("v%0d fills", i), 32'(a_fills), (ek >= 2'd2) ? 32'd1 : 32'd0);
      check(t, $sformatf("v%0d redir", i), 32'(a_redir), (ek == 2'd3) ? 32'd1 : 32'd0);
      if (ek >= 2'd2) begin
        check("R3", $sformatf("v%0d fill_page", i), 32'(a_fpage), 32'(pg));
        check("R3", $sformatf("v%0d stalled", i), 32'(a_stall), 32'd1);
      end
      if (ek == 2'd3)
        check("R6", $sformatf("v%0d redir_page", i), 32'(a_rpage), 32'(pg));
    end

    // R9: stray fill_done while idle has no effect
    @(negedge clk); fill_done = 1'b1; fill_prio = 2'd0;
    @(negedge clk); fill_done = 1'b0;
    check("R9", "no rsp after stray done", 32'(rsp_valid), 32'd0);
    check("R9", "ready after stray done", 32'(req_ready), 32'd1);
    access(12'h310, 2'd0);
    check("R9", "resident after stray done", 32'(a_kind), 32'd0);

    // R9: requests during a stall are ignored
    @(negedge clk); req_valid = 1'b1; req_page = 12'h777;
    @(negedge clk); req_page = 12'h055;
    check("R9", "fill issued", 32'(fill_req), 32'd1);
    @(negedge clk);
    check("R9", "single fill", 32'(fill_req), 32'd0);
    check("R9", "stalled", 32'(req_ready), 32'd0);
    req_valid = 1'b0; fill_done = 1'b1; fill_prio = 2'd2;
    @(negedge clk); fill_done = 1'b0;
    check("R9", "rsp kind", 32'(rsp_kind), 32'd2);
    @(negedge clk);
    check("R9", "no extra fill", 32'(fill_req), 32'd0);
    check("R9", "no extra rsp", 32'(rsp_valid), 32'd0);
    access(12'h777, 2'd0);
    check("R4", "installed page hits", 32'(a_kind), 32'd0);
    access(12'h055, 2'd1);
    check("R9", "stalled request not served", 32'(a_kind), 32'd2);

    // R1: reset in mid-operation discards contents
    do_reset();
    check("R1", "ready after reset", 32'(req_ready), 32'd1);
    access(12'h005, 2'd1);
    check("R1", "content discarded", 32'(a_kind), 32'd2);
    check("R1", "refill count", 32'(a_fills), 32'd1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule